// File: doc/BRIEF.md
# Sensor Front-End Configuration Port

This block is the host-facing register file of an image sensor front end. A host writes configuration bytes either over a three-wire serial link (clock, data, frame enable) or over a strobed 8-bit parallel bus. The block decides which of the two links is live once, right after reset is released, from the level of the shared enable/strobe pin. The stored values leave the block as plain output vectors for the analog and sequencing logic.

The register file holds three setup bytes, a test byte, and three color groups: red, green and blue. Each group has an 8-bit offset DAC code, a DAC sign bit and a 6-bit gain code. A write to a group can target one color or all three at once. Two addresses act as commands rather than storage: one restores every register to its reset value, and the other emits a one-cycle pulse that restarts color sequencing. Readback exists only on the parallel link. The bus is driven only while the host requests a read and the read-enable bit of the test byte is set. The data returned is the register named by the test byte's address field.

All pins are taken through a two-stage synchronizer into the system clock domain. Edges are detected after that.

Top module: `sfe_cfg_port`

## Requirements
- R1: After reset, the outputs hold these values: setup1 = 0x01, setup2 = 0x00, setup3 = 0x02, test = 0x00, all DAC codes, sign bits and gain codes 0, `acyc_restart` low and `bus_oe` low.
- R2: The pin `sen_stb` is sampled once as reset is released. A 1 selects the parallel link and a 0 selects the serial link. The choice is shown on `par_mode` and stays fixed until the next reset.
- R3: A serial write is a frame with `sen_stb` high. On each rising edge of `sck_rnw`, one bit is taken from `sdi_dna`: six address bits from the most significant down, then eight data bits from the most significant down. The write takes effect when `sen_stb` falls.
- R4: A serial frame holding any number of bits other than 14 changes no register.
- R5: In parallel mode the strobe `sen_stb` is active low, and a transfer is taken when the strobe ends (rising edge) with `sck_rnw` = 0. With `sdi_dna` = 0, `bus_in[5:0]` is stored as the address. With `sdi_dna` = 1, `bus_in` is written to the stored address.
- R6: Color groups sit at 0x20–0x23 (DAC code), 0x24–0x27 (DAC sign) and 0x28–0x2B (gain). The two low address bits select the color: 00 red, 01 green, 10 blue, 11 all three. Red occupies the low slice of each packed output.
- R7: Only the defined field bits are stored. These are setup1[3:0] at 0x01, setup2[6:0] at 0x02, setup3[1:0] at 0x03, the sign in bit 0, and the gain in bits 5:0. The test byte at 0x07 is 8 bits wide. Bits outside these fields read back and output as 0.
- R8: A write of any data to 0x04 returns every register to its R1 value.
- R9: A write to 0x05 raises `acyc_restart` for exactly one clock and changes no register.
- R10: `bus_oe` is high only in parallel mode, with `sck_rnw` = 1 and test bit 6 set. In that state `bus_out` carries the register addressed by test bits 5:0, and address 0x06 returns the constant 0x01.
- R11: Writes to addresses outside the map (0x00, 0x08–0x1F, 0x2C–0x3F) are ignored. Reads of those addresses, of the command addresses 0x04/0x05 and of the all-colors addresses 0x23/0x27/0x2B return 0x00.
- R12: In serial mode `bus_oe` stays low whatever the pins and the test byte hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sen_stb | input | 1 | Serial frame enable (high) or parallel strobe (low) |
| sck_rnw | input | 1 | Serial bit clock or parallel read(1)/write(0) |
| sdi_dna | input | 1 | Serial data or parallel data(1)/address(0) |
| bus_in | input | 8 | Parallel bus, input side |
| bus_out | output | 8 | Parallel bus, readback data |
| bus_oe | output | 1 | Drive enable for the parallel bus |
| par_mode | output | 1 | 1 when the parallel link was selected |
| setup1_o | output | 8 | Setup register 1 |
| setup2_o | output | 8 | Setup register 2 |
| setup3_o | output | 8 | Setup register 3 |
| test_o | output | 8 | Test register |
| dac_o | output | 24 | DAC codes, blue/green/red from high to low |
| dac_sign_o | output | 3 | DAC sign bits, blue/green/red |
| pga_gain_o | output | 18 | Gain codes, blue/green/red from high to low |
| acyc_restart | output | 1 | One-cycle color sequencing restart |

## Verification
The following rules are checked on every clock by the embedded properties:
- the restart pulse lasts a single cycle;
- a write to the reset command brings back the default values;
- writes to unmapped addresses leave the register state untouched and reads there return zero;
- the bus is driven only under the parallel-mode and read-enable gate;
- the link choice never moves after it is made;
- a serial commit happens only on the falling edge of the enable.

Frame-length filtering, bit order, the color fan-out of the all-three address, field masking and the readback data can only be shown by the bench. Its scenarios drive whole frames and strobe sequences, then compare every output against a behavioural model of the map.

// File: rtl/sfe_cfg_pkg.sv
package sfe_cfg_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int N_COLOR = 3;
  localparam int GAIN_W = 6;

  localparam logic [5:0] A_SETUP1 = 6'h01;
  localparam logic [5:0] A_SETUP2 = 6'h02;
  localparam logic [5:0] A_SETUP3 = 6'h03;
  localparam logic [5:0] A_SRST   = 6'h04;
  localparam logic [5:0] A_ACYC   = 6'h05;
  localparam logic [5:0] A_ID     = 6'h06;
  localparam logic [5:0] A_TEST   = 6'h07;

  localparam logic [3:0] G_DAC  = 4'b1000;
  localparam logic [3:0] G_SIGN = 4'b1001;
  localparam logic [3:0] G_GAIN = 4'b1010;

  localparam logic [7:0] ID_VAL   = 8'h01;
  localparam logic [7:0] M_SETUP1 = 8'h0F;
  localparam logic [7:0] M_SETUP2 = 8'h7F;
  localparam logic [7:0] M_SETUP3 = 8'h03;
  localparam logic [7:0] D_SETUP1 = 8'h01;
  localparam logic [7:0] D_SETUP3 = 8'h02;

  // group write hit for color c: exact color code or the all-colors code 11
  function automatic logic color_hit(input logic [5:0] a, input logic [3:0] grp, input int c);
    return (a[5:2] == grp) && ((a[1:0] == 2'b11) || (a[1:0] == c[1:0]));
  endfunction

  // address outside every defined register or command
  function automatic logic is_unused(input logic [5:0] a);
    return !(((a >= 6'h01) && (a <= 6'h07)) || ((a[5:4] == 2'b10) && (a[3:2] != 2'b11)));
  endfunction
endpackage

// File: rtl/sfe_pin_sync.sv
module sfe_pin_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= '0;
        else if (g == 0) st[g] <= d;
        else st[g] <= st[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/sfe_ser_rx.sv
module sfe_ser_rx #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          sck,
  input  logic          sen,
  input  logic          sdi,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  localparam int FW = AW + DW;
  localparam int CW = $clog2(FW + 2);

  logic          sck_q, sen_q;
  logic [FW-1:0] shreg;
  logic [CW-1:0] cnt;

  wire sck_rise = sck & ~sck_q;
  wire sen_rise = sen & ~sen_q;
  wire sen_fall = ~sen & sen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      sen_q <= 1'b0;
      shreg <= '0;
      cnt   <= '0;
      we    <= 1'b0;
    end else begin
      sck_q <= sck;
      sen_q <= sen;
      we    <= 1'b0;
      if (en) begin
        if (sen_rise) cnt <= '0;
        else if (sen && sck_rise) begin
          shreg <= {shreg[FW-2:0], sdi};
          if (cnt != CW'(FW + 1)) cnt <= cnt + 1'b1;  // saturate past a full frame
        end
        if (sen_fall && (cnt == CW'(FW))) we <= 1'b1;
      end
    end
  end

  assign addr = shreg[FW-1:DW];
  assign data = shreg[DW-1:0];

  // R3: a serial commit follows the falling edge of the frame enable
  p_commit_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (!sen_q && $past(sen_q)));
endmodule

// File: rtl/sfe_par_rx.sv
module sfe_par_rx #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          stb,
  input  logic          dna,
  input  logic          rnw,
  input  logic [DW-1:0] bus,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  logic stb_q;
  wire  stb_end = stb & ~stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b1;
      addr  <= '0;
      data  <= '0;
      we    <= 1'b0;
    end else begin
      stb_q <= stb;
      we    <= 1'b0;
      if (en && stb_end && !rnw) begin
        if (!dna) addr <= bus[AW-1:0];
        else begin
          data <= bus;
          we   <= 1'b1;
        end
      end
    end
  end

  // R5: a parallel write is taken only at strobe end while in write direction
  p_write_at_strobe_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (stb_q && $past(!rnw && dna)));
endmodule

// File: rtl/sfe_regfile.sv
module sfe_regfile
  import sfe_cfg_pkg::*;
#(
  parameter int DW = 8,
  parameter int NC = 3,
  parameter int GW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [5:0]       waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [5:0]       raddr,
  output logic [DW-1:0]    rdata,
  output logic [DW-1:0]    setup1,
  output logic [DW-1:0]    setup2,
  output logic [DW-1:0]    setup3,
  output logic [DW-1:0]    test,
  output logic [NC*DW-1:0] dac,
  output logic [NC-1:0]    sign,
  output logic [NC*GW-1:0] gain,
  output logic             acyc_pulse
);
  wire soft_clr = we && (waddr == A_SRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup1 <= D_SETUP1; setup2 <= '0; setup3 <= D_SETUP3; test <= '0;
      dac <= '0; sign <= '0; gain <= '0; acyc_pulse <= 1'b0;
    end else if (soft_clr) begin
      setup1 <= D_SETUP1; setup2 <= '0; setup3 <= D_SETUP3; test <= '0;
      dac <= '0; sign <= '0; gain <= '0; acyc_pulse <= 1'b0;
    end else begin
      acyc_pulse <= 1'b0;
      if (we) begin
        case (waddr)
          A_SETUP1: setup1 <= wdata & M_SETUP1;
          A_SETUP2: setup2 <= wdata & M_SETUP2;
          A_SETUP3: setup3 <= wdata & M_SETUP3;
          A_TEST:   test   <= wdata;
          A_ACYC:   acyc_pulse <= 1'b1;
          default: ;
        endcase
        for (int c = 0; c < NC; c++) begin
          if (color_hit(waddr, G_DAC, c))  dac[c*DW +: DW]  <= wdata;
          if (color_hit(waddr, G_SIGN, c)) sign[c]          <= wdata[0];
          if (color_hit(waddr, G_GAIN, c)) gain[c*GW +: GW] <= wdata[GW-1:0];
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (raddr)
      A_SETUP1: rdata = setup1;
      A_SETUP2: rdata = setup2;
      A_SETUP3: rdata = setup3;
      A_ID:     rdata = ID_VAL;
      A_TEST:   rdata = test;
      default: ;
    endcase
    for (int c = 0; c < NC; c++) begin
      if (raddr == {G_DAC, 2'(c)})  rdata = dac[c*DW +: DW];
      if (raddr == {G_SIGN, 2'(c)}) rdata = DW'(sign[c]);
      if (raddr == {G_GAIN, 2'(c)}) rdata = DW'(gain[c*GW +: GW]);
    end
  end

  wire [4*DW+NC*DW+NC+NC*GW-1:0] state_cat = {setup1, setup2, setup3, test, dac, sign, gain};

  // R9: restart pulse is one cycle wide
  p_acyc_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acyc_pulse |=> !acyc_pulse);
  // R9: the restart command leaves register state alone
  p_acyc_no_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == A_ACYC) |=> $stable(state_cat));
  // R8: reset command restores defaults
  p_srst_defaults_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (setup1 == D_SETUP1 && setup2 == '0 && setup3 == D_SETUP3 &&
                  test == '0 && dac == '0 && sign == '0 && gain == '0));
  // R11: unmapped writes change nothing
  p_unused_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (we && is_unused(waddr)) |=> $stable(state_cat));
  // R11: unmapped reads return zero
  p_unused_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    is_unused(raddr) |-> (rdata == '0));
endmodule

// File: rtl/sfe_cfg_port.sv
module sfe_cfg_port
  import sfe_cfg_pkg::*;
#(
  parameter int DW          = DATA_W,
  parameter int AW          = ADDR_W,
  parameter int NC          = N_COLOR,
  parameter int GW          = GAIN_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sen_stb,
  input  logic             sck_rnw,
  input  logic             sdi_dna,
  input  logic [DW-1:0]    bus_in,
  output logic [DW-1:0]    bus_out,
  output logic             bus_oe,
  output logic             par_mode,
  output logic [DW-1:0]    setup1_o,
  output logic [DW-1:0]    setup2_o,
  output logic [DW-1:0]    setup3_o,
  output logic [DW-1:0]    test_o,
  output logic [NC*DW-1:0] dac_o,
  output logic [NC-1:0]    dac_sign_o,
  output logic [NC*GW-1:0] pga_gain_o,
  output logic             acyc_restart
);
  localparam int ACW = $clog2(SYNC_STAGES + 1);
  localparam int RD_EN_BIT = 6;

  logic [DW+2:0] pins_s;
  logic          stb_s, rnw_s, dna_s;
  logic [DW-1:0] bus_s;

  sfe_pin_sync #(.W(DW + 3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sen_stb, sck_rnw, sdi_dna, bus_in}), .q(pins_s));
  assign {stb_s, rnw_s, dna_s, bus_s} = pins_s;

  // link choice: taken once the synchronizer holds post-reset pin levels
  logic [ACW-1:0] arm_cnt;
  logic           armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_cnt  <= '0;
      armed    <= 1'b0;
      par_mode <= 1'b0;
    end else if (!armed) begin
      if (arm_cnt == ACW'(SYNC_STAGES)) begin
        armed    <= 1'b1;
        par_mode <= stb_s;
      end else arm_cnt <= arm_cnt + 1'b1;
    end
  end

  logic          s_we, p_we;
  logic [AW-1:0] s_addr, p_addr;
  logic [DW-1:0] s_data, p_data;

  sfe_ser_rx #(.AW(AW), .DW(DW)) u_ser (
    .clk(clk), .rst_n(rst_n), .en(armed && !par_mode),
    .sck(rnw_s), .sen(stb_s), .sdi(dna_s),
    .we(s_we), .addr(s_addr), .data(s_data));

  sfe_par_rx #(.AW(AW), .DW(DW)) u_par (
    .clk(clk), .rst_n(rst_n), .en(armed && par_mode),
    .stb(stb_s), .dna(dna_s), .rnw(rnw_s), .bus(bus_s),
    .we(p_we), .addr(p_addr), .data(p_data));

  wire          wr_en   = par_mode ? p_we : s_we;
  wire [AW-1:0] wr_addr = par_mode ? p_addr : s_addr;
  wire [DW-1:0] wr_data = par_mode ? p_data : s_data;
  logic [DW-1:0] rd_data;

  sfe_regfile #(.DW(DW), .NC(NC), .GW(GW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(test_o[AW-1:0]), .rdata(rd_data),
    .setup1(setup1_o), .setup2(setup2_o), .setup3(setup3_o), .test(test_o),
    .dac(dac_o), .sign(dac_sign_o), .gain(pga_gain_o), .acyc_pulse(acyc_restart));

  assign bus_oe  = armed && par_mode && rnw_s && test_o[RD_EN_BIT];
  assign bus_out = bus_oe ? rd_data : '0;

  // R2: the link choice never changes once made
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(armed)) |-> $stable(par_mode));
  // R10: bus driven only with read enable in parallel mode
  p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (par_mode && test_o[RD_EN_BIT]));
  // R12: the serial link never drives the bus
  p_serial_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !par_mode |-> !bus_oe);
endmodule

// File: tb/sfe_cfg_port_tb.sv
module sfe_cfg_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sen_stb = 1'b0, sck_rnw = 1'b0, sdi_dna = 1'b0;
  logic [7:0]  bus_in = '0;
  logic [7:0]  bus_out, setup1_o, setup2_o, setup3_o, test_o;
  logic        bus_oe, par_mode, acyc_restart;
  logic [23:0] dac_o;
  logic [2:0]  dac_sign_o;
  logic [17:0] pga_gain_o;

  always #10 clk = ~clk;

  sfe_cfg_port u_dut (
    .clk(clk), .rst_n(rst_n), .sen_stb(sen_stb), .sck_rnw(sck_rnw), .sdi_dna(sdi_dna),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .par_mode(par_mode),
    .setup1_o(setup1_o), .setup2_o(setup2_o), .setup3_o(setup3_o), .test_o(test_o),
    .dac_o(dac_o), .dac_sign_o(dac_sign_o), .pga_gain_o(pga_gain_o),
    .acyc_restart(acyc_restart));

  int checks = 0, errors = 0;
  int pulses_seen = 0, pulses_exp = 0;
  bit cmp_en = 0;
  logic [7:0] m [64];   // model: readback value per address

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_defaults();
    for (int i = 0; i < 64; i++) m[i] = 8'h00;
    m[1] = 8'h01; m[3] = 8'h02; m[6] = 8'h01;
  endtask

  task automatic model_write(input logic [5:0] a, input logic [7:0] d);
    if (a == 6'h04) model_defaults();
    else if (a == 6'h05) pulses_exp++;
    else if (a == 6'h01) m[1] = d & 8'h0F;
    else if (a == 6'h02) m[2] = d & 8'h7F;
    else if (a == 6'h03) m[3] = d & 8'h03;
    else if (a == 6'h07) m[7] = d;
    else if (a[5:4] == 2'b10 && a[3:2] != 2'b11) begin
      for (int c = 0; c < 3; c++)
        if (a[1:0] == 2'b11 || a[1:0] == c[1:0])
          m[32 + a[3:2]*4 + c] = (a[3:2] == 0) ? d : (a[3:2] == 1) ? (d & 8'h01) : (d & 8'h3F);
    end
  endtask

  // every-clock comparison of the register outputs with the model
  always @(negedge clk) begin
    if (cmp_en) begin
      check("R1/R6/R7 model setup1", setup1_o, m[1]);
      check("R7 model setup2", setup2_o, m[2]);
      check("R7 model setup3", setup3_o, m[3]);
      check("R10 model test", test_o, m[7]);
      check("R6 model dac", dac_o, {m[34], m[33], m[32]});
      check("R6 model sign", dac_sign_o, {m[38][0], m[37][0], m[36][0]});
      check("R6 model gain", pga_gain_o, {m[42][5:0], m[41][5:0], m[40][5:0]});
    end
  end

  always @(posedge clk) if (rst_n && acyc_restart) pulses_seen++;

  task automatic do_reset(input logic par);
    cmp_en = 0;
    @(negedge clk);
    rst_n = 0; sen_stb = par; sck_rnw = 0; sdi_dna = 0; bus_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (8) @(negedge clk);
    model_defaults();
    pulses_seen = 0; pulses_exp = 0;
    cmp_en = 1;
  endtask

  task automatic ser_frame(input logic [15:0] v, input int n);
    cmp_en = 0;
    sen_stb = 1; repeat (3) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdi_dna = v[i];
      sck_rnw = 0; repeat (2) @(negedge clk);
      sck_rnw = 1; repeat (3) @(negedge clk);
      sck_rnw = 0; repeat (2) @(negedge clk);
    end
    sen_stb = 0; repeat (6) @(negedge clk);
  endtask

  task automatic ser_write(input logic [5:0] a, input logic [7:0] d);
    ser_frame({2'b00, a, d}, 14);
    model_write(a, d);
    cmp_en = 1;
  endtask

  task automatic strobe();
    repeat (3) @(negedge clk);
    sen_stb = 0; repeat (3) @(negedge clk);
    sen_stb = 1; repeat (3) @(negedge clk);
  endtask

  task automatic par_write(input logic [5:0] a, input logic [7:0] d);
    cmp_en = 0;
    sck_rnw = 0; sdi_dna = 0; bus_in = {2'b00, a}; strobe();
    sdi_dna = 1; bus_in = d; strobe();
    repeat (3) @(negedge clk);
    model_write(a, d);
    cmp_en = 1;
  endtask

  task automatic par_read(input logic [5:0] a, input string tag);
    par_write(6'h07, 8'h40 | {2'b00, a});
    sck_rnw = 1; repeat (5) @(negedge clk);
    check({tag, " oe"}, bus_oe, 1'b1);
    check({tag, " data"}, bus_out, m[a]);
    sck_rnw = 0; repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // serial link
    do_reset(1'b0);
    check("R1 setup1 default", setup1_o, 8'h01);
    check("R1 setup3 default", setup3_o, 8'h02);
    check("R1 gain default", pga_gain_o, 18'h0);
    check("R1 oe default", bus_oe, 1'b0);
    check("R2 serial chosen", par_mode, 1'b0);

    ser_write(6'h02, 8'h55);
    check("R3 serial setup2", setup2_o, 8'h55);
    ser_write(6'h01, 8'hFF);
    check("R7 setup1 mask", setup1_o, 8'h0F);
    ser_write(6'h21, 8'hA5);
    check("R6 green dac", dac_o, 24'h00A500);
    ser_write(6'h2B, 8'hFF);
    check("R6 gain broadcast", pga_gain_o, {6'h3F, 6'h3F, 6'h3F});
    ser_write(6'h24, 8'hFF);
    check("R7 red sign bit", dac_sign_o, 3'b001);

    ser_frame({3'b000, 6'h02, 7'h11}, 13);   // short frame
    cmp_en = 1;
    check("R4 short frame ignored", setup2_o, 8'h55);
    ser_frame({1'b1, 1'b0, 6'h02, 8'h22}, 15); // long frame
    cmp_en = 1;
    check("R4 long frame ignored", setup2_o, 8'h55);

    ser_write(6'h08, 8'hFF);
    ser_write(6'h30, 8'hFF);
    ser_write(6'h2C, 8'hFF);
    check("R11 reserved ignored", setup2_o, 8'h55);

    ser_write(6'h05, 8'h00);
    check("R9 one restart pulse", pulses_seen, pulses_exp);
    check("R9 registers kept", dac_o, 24'h00A500);

    ser_write(6'h07, 8'h46);
    sck_rnw = 1; repeat (6) @(negedge clk);
    check("R12 serial bus idle", bus_oe, 1'b0);
    check("R2 serial kept", par_mode, 1'b0);
    sck_rnw = 0; repeat (3) @(negedge clk);

    ser_write(6'h04, 8'hAA);
    check("R8 soft reset setup1", setup1_o, 8'h01);
    check("R8 soft reset gain", pga_gain_o, 18'h0);
    check("R8 soft reset test", test_o, 8'h00);

    // parallel link
    do_reset(1'b1);
    check("R2 parallel chosen", par_mode, 1'b1);
    par_write(6'h03, 8'hFF);
    check("R5 parallel setup3", setup3_o, 8'h03);
    par_write(6'h22, 8'h7E);
    check("R6 blue dac", dac_o, 24'h7E0000);
    par_write(6'h27, 8'hFF);
    check("R6 sign broadcast", dac_sign_o, 3'b111);
    par_write(6'h28, 8'h2A);
    check("R6 red gain", pga_gain_o, 18'h0002A);

    par_read(6'h06, "R10 id");
    par_read(6'h22, "R10 blue dac");
    par_read(6'h07, "R10 test self");
    par_read(6'h28, "R7 gain readback");
    par_read(6'h09, "R11 reserved read");
    par_read(6'h23, "R11 broadcast read");
    par_read(6'h04, "R11 command read");

    par_write(6'h07, 8'h06);
    sck_rnw = 1; repeat (5) @(negedge clk);
    check("R10 read disabled", bus_oe, 1'b0);
    sck_rnw = 0; repeat (3) @(negedge clk);
    check("R2 parallel kept", par_mode, 1'b1);

    par_write(6'h05, 8'h00);
    check("R9 parallel restart", pulses_seen, pulses_exp);

    cmp_en = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule